// File: doc/BRIEF.md
# ADC Gain Calibration Sequencer

This block runs a gain-calibration pass for an analog-to-digital converter whenever software asks for one. At the start request it takes a snapshot of which channels are enabled and which gain setting each one uses. It then walks the channels from the lowest index upward. For each gain setting it meets for the first time in the pass, it asks an external analog calibration step for a correction word. That step is modelled here by a request/acknowledge handshake. Results are kept per gain setting, not per channel. A channel that is enabled later, or that is moved onto a setting that is already calibrated, benefits at once without another pass.

Completion raises an end-of-calibration flag, which a status read clears, and an interrupt that follows the flag only when its enable is set. A software reset or a power-up reset discards all stored results. A reference-voltage change marks every stored result stale. The conversion path looks up the current setting of the converted channel and adds the stored signed correction, saturating to the data range, when that setting is valid. Otherwise it forwards the raw sample unchanged.

Top module: `gain_cal_seq`

## Requirements
- R1: A one-cycle `cal_start` while idle starts a pass: `busy` is high from the next clock edge until the pass ends.
- R2: A pass handles only channels enabled at the start edge, in ascending channel order, and requests each distinct gain setting exactly once. Disabled channels and settings already handled in the pass are skipped. Channel c's setting sits in `ch_gain[c*GW +: GW]`.
- R3: `cal_req` stays high with a stable `cal_gain` until `cal_ack`. The `cal_corr` word, a two's-complement value, is then stored in that setting's slot and its `set_valid` bit is set.
- R4: When a pass ends, `eoc` is set in the same cycle that `busy` falls, and `stat_read` clears it.
- R5: `irq` rises together with `eoc` only when `irq_en` is high, and it clears with `eoc`.
- R6: A `cal_start` that arrives while a pass is running has no effect: no extra requests are made and no second pass follows.
- R7: Power-up reset (`rst`) or `sw_reset` clears every `set_valid` bit and `eoc`, and aborts a running pass, so `busy` and `cal_req` drop on the next edge.
- R8: A `ref_change` pulse clears every `set_valid` bit.
- R9: A channel switched to a setting that is already valid gets calibrated output with no new pass. A channel switched to an invalid setting gets raw output.
- R10: The conversion result appears one cycle after `conv_valid`. If the setting of `conv_ch` is valid, `out_data` is clamp(raw + correction, 0, 2^DW-1) and `out_cal`=1. Otherwise `out_data` is the raw value and `out_cal`=0.
- R11: A pass only sets valid bits. It never clears the valid bit of a setting it did not touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cal_start | input | 1 | Start-calibration pulse |
| sw_reset | input | 1 | Software reset pulse |
| ref_change | input | 1 | Reference voltage changed pulse |
| stat_read | input | 1 | Status read strobe, clears end-of-calibration flag |
| irq_en | input | 1 | Interrupt enable for end-of-calibration |
| ch_enable | input | NCH | Channel enable mask |
| ch_gain | input | NCH*GW | Gain setting per channel, packed |
| cal_req | output | 1 | Request to the analog calibration step |
| cal_gain | output | GW | Setting being calibrated |
| cal_ack | input | 1 | Calibration step done |
| cal_corr | input | CW | Correction word returned with the acknowledge |
| busy | output | 1 | Pass in progress |
| eoc | output | 1 | End-of-calibration flag |
| irq | output | 1 | End-of-calibration interrupt |
| set_valid | output | 2**GW | Valid bit per gain setting |
| set_corr | output | (2**GW)*CW | Stored correction per setting, packed |
| conv_valid | input | 1 | Raw conversion sample present |
| conv_ch | input | $clog2(NCH) | Channel of the sample |
| conv_raw | input | DW | Raw sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | DW | Corrected or raw sample |
| out_cal | output | 1 | Output sample was calibrated |

## Verification
The sequencer is swept over all sixteen enable masks of a four-channel configuration, and each mask is paired with sixteen gain assignments. Some assignments repeat settings across channels and some use all four, so the test separates per-setting deduplication and ascending scan order from a naive per-channel pass. Passes with and without a preceding software reset distinguish accumulation of valid bits from replacement. After each pass a conversion on every channel compares the corrected or raw output against the bench's own table. Directed cases cover saturation at both rails, reuse after a gain change, reference invalidation, restart while busy and reset in mid-pass.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_WAIT = 2'd2,
    S_DONE = 2'd3
  } gcal_state_e;
endpackage

// File: rtl/gcal_seq.sv
module gcal_seq
  import gcal_pkg::*;
#(
  parameter int NCH = 8,
  parameter int GW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_reset,
  input  logic              cal_start,
  input  logic              stat_read,
  input  logic              irq_en,
  input  logic [NCH-1:0]    ch_enable,
  input  logic [NCH*GW-1:0] ch_gain,
  output logic              cal_req,
  output logic [GW-1:0]     cal_gain,
  input  logic              cal_ack,
  output logic              wr_en,
  output logic [GW-1:0]     wr_addr,
  output logic              busy,
  output logic              eoc,
  output logic              irq
);
  localparam int NG = 1 << GW;
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [IW-1:0] LAST = IW'(NCH - 1);

  gcal_state_e       state_q;
  logic [IW-1:0]     idx_q;
  logic [NCH-1:0]    en_snap_q;
  logic [NCH*GW-1:0] gain_snap_q;
  logic [NG-1:0]     seen_q;
  logic              req_q;
  logic [GW-1:0]     gain_q;
  logic              eoc_q;
  logic              irq_q;
  logic              eoc_d;
  logic [GW-1:0]     cur_g;

  assign cur_g = gain_snap_q[idx_q*GW +: GW];

  always_comb begin
    if (state_q == S_DONE)  eoc_d = 1'b1;
    else if (stat_read)     eoc_d = 1'b0;
    else                    eoc_d = eoc_q;
  end

  always_ff @(posedge clk) begin
    if (rst || sw_reset) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      en_snap_q   <= '0;
      gain_snap_q <= '0;
      seen_q      <= '0;
      req_q       <= 1'b0;
      gain_q      <= '0;
      eoc_q       <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      eoc_q <= eoc_d;
      irq_q <= eoc_d & irq_en;
      unique case (state_q)
        S_IDLE: begin
          if (cal_start) begin
            en_snap_q   <= ch_enable;
            gain_snap_q <= ch_gain;
            idx_q       <= '0;
            seen_q      <= '0;
            state_q     <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (en_snap_q[idx_q] && !seen_q[cur_g]) begin
            req_q   <= 1'b1;
            gain_q  <= cur_g;
            state_q <= S_WAIT;
          end else if (idx_q == LAST) begin
            state_q <= S_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_WAIT: begin
          if (cal_ack) begin
            req_q          <= 1'b0;
            seen_q[gain_q] <= 1'b1;
            if (idx_q == LAST) begin
              state_q <= S_DONE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= S_SCAN;
            end
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cal_req  = req_q;
  assign cal_gain = gain_q;
  assign wr_en    = (state_q == S_WAIT) && cal_ack;
  assign wr_addr  = gain_q;
  assign busy     = (state_q != S_IDLE);
  assign eoc      = eoc_q;
  assign irq      = irq_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst || sw_reset)
    (cal_req && !cal_ack) |=> (cal_req && $stable(cal_gain)));

  // R2
  new_setting_chk: assert property (@(posedge clk) disable iff (rst || sw_reset)
    (state_q == S_WAIT) |-> !seen_q[gain_q]);

  // R4
  eoc_after_done_chk: assert property (@(posedge clk) disable iff (rst || sw_reset)
    $rose(eoc_q) |-> $past(state_q == S_DONE));

  // R5
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst || sw_reset)
    ($rose(eoc_q) && $past(irq_en)) |-> irq_q);
endmodule

// File: rtl/gcal_store.sv
module gcal_store #(
  parameter int GW = 2,
  parameter int CW = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sw_reset,
  input  logic                   ref_change,
  input  logic                   wr_en,
  input  logic [GW-1:0]          wr_addr,
  input  logic [CW-1:0]          wr_data,
  output logic [(1<<GW)-1:0]     valid,
  output logic [(1<<GW)*CW-1:0]  corr_flat
);
  localparam int NG = 1 << GW;

  logic [NG-1:0] valid_q;
  logic [CW-1:0] mem [NG];

  always_ff @(posedge clk) begin
    if (rst || sw_reset || ref_change) valid_q <= '0;
    else if (wr_en)                    valid_q[wr_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  generate
    for (genvar g = 0; g < NG; g++) begin : g_out
      assign corr_flat[g*CW +: CW] = mem[g];
    end
  endgenerate

  assign valid = valid_q;

  // R7
  clear_on_swrst_chk: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> (valid_q == '0));

  // R8
  clear_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
    ref_change |=> (valid_q == '0));
endmodule

// File: rtl/gcal_apply.sv
module gcal_apply #(
  parameter int NCH = 8,
  parameter int GW  = 2,
  parameter int CW  = 12,
  parameter int DW  = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          conv_valid,
  input  logic [$clog2(NCH)-1:0]        conv_ch,
  input  logic [DW-1:0]                 conv_raw,
  input  logic [NCH*GW-1:0]             ch_gain,
  input  logic [(1<<GW)-1:0]            valid,
  input  logic [(1<<GW)*CW-1:0]         corr_flat,
  output logic                          out_valid,
  output logic [DW-1:0]                 out_data,
  output logic                          out_cal
);
  localparam int SW = ((DW > CW) ? DW : CW) + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

  logic [GW-1:0]          g;
  logic [CW-1:0]          corr;
  logic signed [SW-1:0]   sum;
  logic [DW-1:0]          clamped;

  assign g    = ch_gain[conv_ch*GW +: GW];
  assign corr = corr_flat[g*CW +: CW];

  always_comb begin
    sum = SW'($signed({1'b0, conv_raw})) + SW'($signed(corr));
    if (sum < 0)         clamped = '0;
    else if (sum > MAXV) clamped = MAXV[DW-1:0];
    else                 clamped = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_cal   <= 1'b0;
    end else begin
      out_valid <= conv_valid;
      if (conv_valid) begin
        out_cal  <= valid[g];
        out_data <= valid[g] ? clamped : conv_raw;
      end
    end
  end

  // R10
  raw_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_cal) |-> (out_data == $past(conv_raw)));
endmodule

// File: rtl/gain_cal_seq.sv
module gain_cal_seq #(
  parameter int NCH = 8,
  parameter int GW  = 2,
  parameter int CW  = 12,
  parameter int DW  = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cal_start,
  input  logic                        sw_reset,
  input  logic                        ref_change,
  input  logic                        stat_read,
  input  logic                        irq_en,
  input  logic [NCH-1:0]              ch_enable,
  input  logic [NCH*GW-1:0]           ch_gain,
  output logic                        cal_req,
  output logic [GW-1:0]               cal_gain,
  input  logic                        cal_ack,
  input  logic [CW-1:0]               cal_corr,
  output logic                        busy,
  output logic                        eoc,
  output logic                        irq,
  output logic [(1<<GW)-1:0]          set_valid,
  output logic [(1<<GW)*CW-1:0]       set_corr,
  input  logic                        conv_valid,
  input  logic [$clog2(NCH)-1:0]      conv_ch,
  input  logic [DW-1:0]               conv_raw,
  output logic                        out_valid,
  output logic [DW-1:0]               out_data,
  output logic                        out_cal
);
  logic          wr_en;
  logic [GW-1:0] wr_addr;

  gcal_seq #(.NCH(NCH), .GW(GW)) u_seq (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .cal_start(cal_start),
    .stat_read(stat_read), .irq_en(irq_en), .ch_enable(ch_enable),
    .ch_gain(ch_gain), .cal_req(cal_req), .cal_gain(cal_gain),
    .cal_ack(cal_ack), .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy),
    .eoc(eoc), .irq(irq)
  );

  gcal_store #(.GW(GW), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .ref_change(ref_change),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(cal_corr),
    .valid(set_valid), .corr_flat(set_corr)
  );

  gcal_apply #(.NCH(NCH), .GW(GW), .CW(CW), .DW(DW)) u_apply (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_ch(conv_ch),
    .conv_raw(conv_raw), .ch_gain(ch_gain), .valid(set_valid),
    .corr_flat(set_corr), .out_valid(out_valid), .out_data(out_data),
    .out_cal(out_cal)
  );
endmodule

// File: tb/tb_gain_cal_seq.sv
module tb_gain_cal_seq;
  localparam int NCH = 4;
  localparam int GW  = 2;
  localparam int CW  = 12;
  localparam int DW  = 12;
  localparam int NG  = 1 << GW;
  localparam int STUB_DLY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_start = 0, sw_reset = 0, ref_change = 0, stat_read = 0, irq_en = 0;
  logic [NCH-1:0] ch_enable = '0;
  logic [NCH*GW-1:0] ch_gain = '0;
  logic cal_req;
  logic [GW-1:0] cal_gain;
  logic cal_ack = 0;
  logic [CW-1:0] cal_corr = '0;
  logic busy, eoc, irq;
  logic [NG-1:0] set_valid;
  logic [NG*CW-1:0] set_corr;
  logic conv_valid = 0;
  logic [$clog2(NCH)-1:0] conv_ch = '0;
  logic [DW-1:0] conv_raw = '0;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic out_cal;

  int nchk = 0;
  int nbad = 0;
  int nlog = 0;
  int log_g [16];
  int stub_cnt = 0;
  logic [NG-1:0] model_valid = '0;

  always #10 clk = ~clk;

  gain_cal_seq #(.NCH(NCH), .GW(GW), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .sw_reset(sw_reset),
    .ref_change(ref_change), .stat_read(stat_read), .irq_en(irq_en),
    .ch_enable(ch_enable), .ch_gain(ch_gain), .cal_req(cal_req),
    .cal_gain(cal_gain), .cal_ack(cal_ack), .cal_corr(cal_corr),
    .busy(busy), .eoc(eoc), .irq(irq), .set_valid(set_valid),
    .set_corr(set_corr), .conv_valid(conv_valid), .conv_ch(conv_ch),
    .conv_raw(conv_raw), .out_valid(out_valid), .out_data(out_data),
    .out_cal(out_cal)
  );

  function automatic int corr_of(int g);
    return g * 300 - 400;
  endfunction

  // analog calibration stub
  always @(negedge clk) begin
    if (cal_ack) begin
      cal_ack = 1'b0;
    end else if (cal_req) begin
      if (stub_cnt == STUB_DLY) begin
        cal_ack  = 1'b1;
        cal_corr = CW'(corr_of(int'(cal_gain)));
        if (nlog < 16) log_g[nlog] = int'(cal_gain);
        nlog++;
        stub_cnt = 0;
      end else begin
        stub_cnt++;
      end
    end else begin
      stub_cnt = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_swrst();
    sw_reset = 1'b1; cyc(1); sw_reset = 1'b0;
    model_valid = '0;
  endtask

  task automatic start_pass();
    cal_start = 1'b1; cyc(1); cal_start = 1'b0;
    chk("R1 busy after start", int'(busy), 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) cyc(1);
  endtask

  function automatic int gain_at(logic [NCH*GW-1:0] gv, int c);
    return int'((gv >> (c*GW)) & ((1 << GW) - 1));
  endfunction

  task automatic conv_check(string req, int c, int raw);
    int g, v, ecal;
    g = gain_at(ch_gain, c);
    if (model_valid[g]) begin
      v = raw + corr_of(g);
      if (v < 0) v = 0;
      if (v > (1 << DW) - 1) v = (1 << DW) - 1;
      ecal = 1;
    end else begin
      v = raw; ecal = 0;
    end
    conv_valid = 1'b1; conv_ch = c[$clog2(NCH)-1:0]; conv_raw = DW'(raw);
    cyc(1);
    conv_valid = 1'b0;
    chk({req, " out_valid"}, int'(out_valid), 1);
    chk({req, " out_data"}, int'(out_data), v);
    chk({req, " out_cal"}, int'(out_cal), ecal);
  endtask

  // full pass with expected request list computed here
  task automatic run_and_check(logic ie);
    int exp_g [16];
    int ne;
    logic [NG-1:0] seen;
    seen = '0; ne = 0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_enable[c] && !seen[gain_at(ch_gain, c)]) begin
        exp_g[ne] = gain_at(ch_gain, c);
        seen[gain_at(ch_gain, c)] = 1'b1;
        ne++;
      end
    end
    irq_en = ie;
    nlog = 0;
    start_pass();
    wait_idle();
    chk("R2 request count", nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++) chk("R2 request order", log_g[i], exp_g[i]);
    model_valid = model_valid | seen;
    chk("R3 R11 valid bits", int'(set_valid), int'(model_valid));
    chk("R4 eoc at end", int'(eoc), 1);
    chk("R5 irq gated", int'(irq), int'(ie));
    stat_read = 1'b1; cyc(1); stat_read = 1'b0;
    chk("R4 eoc cleared by read", int'(eoc), 0);
    chk("R5 irq cleared", int'(irq), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R7 power-up state
    chk("R7 reset busy", int'(busy), 0);
    chk("R7 reset eoc", int'(eoc), 0);
    chk("R7 reset irq", int'(irq), 0);
    chk("R7 reset valid", int'(set_valid), 0);
    chk("R7 reset req", int'(cal_req), 0);

    // sweep over masks and gain assignments
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 16; k++) begin
        if (k % 2 == 0) pulse_swrst();
        ch_enable = NCH'(m);
        ch_gain   = (NCH*GW)'((k * 37 + m * 11) & 255);
        run_and_check(k[1]);
        for (int c = 0; c < NCH; c++)
          conv_check("R10 sweep", c, (c * 1123 + (m*16+k) * 29) % 4096);
      end
    end

    // saturation: channel c on setting c
    pulse_swrst();
    ch_enable = '1;
    ch_gain   = 8'b11_10_01_00;
    run_and_check(1'b1);
    conv_check("R10 sat high", 3, 4095);
    conv_check("R10 sat high edge", 3, 3595);
    conv_check("R10 below high", 3, 3594);
    conv_check("R10 sat low", 0, 0);
    conv_check("R10 sat low mid", 0, 200);
    conv_check("R10 low edge", 0, 401);
    conv_check("R10 negative mid", 1, 2000);

    // R9 reuse on gain change without a pass
    nlog = 0;
    ch_gain = 8'b11_10_11_00;
    conv_check("R9 reuse calibrated", 1, 1000);
    chk("R9 no request", nlog, 0);

    pulse_swrst();
    ch_enable = 4'b0001;
    ch_gain   = 8'b00_00_00_00;
    run_and_check(1'b0);
    ch_enable = 4'b0011;
    ch_gain   = 8'b00_00_10_00;
    conv_check("R9 new setting raw", 1, 1234);
    conv_check("R9 old setting cal", 0, 1234);

    // R8 reference change
    ref_change = 1'b1; cyc(1); ref_change = 1'b0;
    model_valid = '0;
    chk("R8 valid cleared", int'(set_valid), 0);
    conv_check("R8 raw after ref", 0, 1234);

    // R6 start while busy
    ch_enable = '1;
    ch_gain   = 8'b00_01_10_11;
    nlog = 0;
    irq_en = 1'b0;
    start_pass();
    cyc(3);
    cal_start = 1'b1; cyc(1); cal_start = 1'b0;
    cyc(6);
    cal_start = 1'b1; cyc(1); cal_start = 1'b0;
    wait_idle();
    model_valid = '1;
    cyc(20);
    chk("R6 request count", nlog, 4);
    chk("R6 still idle", int'(busy), 0);
    chk("R6 valid", int'(set_valid), 15);
    stat_read = 1'b1; cyc(1); stat_read = 1'b0;

    // R7 software reset mid-pass
    nlog = 0;
    start_pass();
    cyc(4);
    sw_reset = 1'b1; cyc(1); sw_reset = 1'b0;
    model_valid = '0;
    chk("R7 abort busy", int'(busy), 0);
    chk("R7 abort req", int'(cal_req), 0);
    chk("R7 abort valid", int'(set_valid), 0);
    chk("R7 abort eoc", int'(eoc), 0);
    cyc(10);
    chk("R7 stays idle", int'(busy), 0);
    conv_check("R7 raw after reset", 2, 777);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule